// File: doc/BRIEF.md
# Write-Once Outer Bank Latch

This block widens a standard inner bank-switching mapper so that one board can hold several games in a 1 MiB program ROM and a 1 MiB character ROM. It snoops CPU writes to the 6000h–7FFFh window (the writes still reach the work RAM there) and captures the first byte written after reset into an 8-bit configuration latch. From then on the latch is locked, and only a reset clears it.

The latched byte is combined with bit 17 of the inner mapper's program and character bank outputs. The result is a 3-bit number for each ROM that selects one 128K bank. For each ROM a mode bit chooses one of two behaviours. The bank's low bit can be a fixed half taken from the latch, or it can follow the inner mapper's A17, which gives a 256K window. One select bit is shared by both ROMs. The full ROM address is the 3-bit bank followed by the inner mapper's A16..A0.

Top module: `outer_bank_latch`

## Requirements
- R1: A synchronous active-high reset clears the latch to 00h and unlocks it. After reset, with byte 00h, both bank numbers are {0,0,inner A17}.
- R2: A write is recognised only when `cpuWrite` is high at a rising clock edge and `cpuAddr[15:13]` equals 011b. The low address bits do not matter.
- R3: The first recognised write after reset loads `cpuData` into the latch. The new byte affects the ROM addresses from the cycle after that edge.
- R4: Every recognised write after the first one is ignored until the next reset. A reset re-arms the latch for one more write.
- R5: Latch bit meanings are as follows. Bit 6 is the character mode bit (1 = fixed half). Bit 5 is the character upper select. Bit 4 is the character half. Bit 3 is the program mode bit (1 = fixed half). Bit 2 is the shared select. Bit 1 is the program select. Bit 0 is the program half. Bit 7 has no effect on any output.
- R6: The program bank number is {bit2, bit1, bit3 ? bit0 : innerProgA17}.
- R7: The character bank number is {bit5, bit2, bit6 ? bit4 : innerCharA17}.
- R8: Bit 2 drives program bank bit 2 and character bank bit 1 at the same time.
- R9: `progRomAddr` is {program bank, innerProgLow}. `charRomAddr` is {character bank, innerCharLow}. Both are combinational, so a change on an inner input shows up in the same cycle.
- R10: A write with `cpuAddr[15:13]` not equal to 011b, or any cycle with `cpuWrite` low, leaves the latch and the lock unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpuAddr | input | 16 | CPU address bus |
| cpuData | input | 8 | CPU write data |
| cpuWrite | input | 1 | CPU write strobe, sampled at the rising edge |
| innerProgA17 | input | 1 | Inner mapper program bank A17 |
| innerCharA17 | input | 1 | Inner mapper character bank A17 |
| innerProgLow | input | 17 | Inner mapper program A16..A0 |
| innerCharLow | input | 17 | Inner mapper character A16..A0 |
| progRomAddr | output | 20 | Full program ROM address |
| charRomAddr | output | 20 | Full character ROM address |

## Verification
The latch result is due one rising edge after the write. The bench drives each write on a falling edge and checks the outputs at the following falling edge, after exactly one capturing edge. The ROM addresses depend on the inner inputs with no clock in between. The bench changes those inputs and samples 1 ns later within the same cycle. Every one of the 256 latch values is loaded after a fresh reset and checked against all four inner A17 combinations. Ignored writes are checked through bank-exposing bytes, and reset re-arming is checked the same way.

// File: rtl/obl_pkg.sv
package obl_pkg;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam int LOW_W    = 17;
  localparam int BANK_W   = 3;
  localparam int ROM_W    = BANK_W + LOW_W;
  localparam int WIN_MSB  = ADDR_W - 1;
  localparam int WIN_LSB  = 13;
  localparam int WIN_W    = WIN_MSB - WIN_LSB + 1;
  localparam logic [WIN_W-1:0] WIN_MATCH = 3'b011;

  // bit positions inside the configuration byte
  localparam int B_CHAR_MODE  = 6;
  localparam int B_CHAR_UPPER = 5;
  localparam int B_CHAR_HALF  = 4;
  localparam int B_PROG_MODE  = 3;
  localparam int B_SHARED     = 2;
  localparam int B_PROG_SEL   = 1;
  localparam int B_PROG_HALF  = 0;

  typedef struct packed {
    logic hit;   // recognised write in the window
    logic load;  // capture data into the latch this edge
  } obl_strobe_t;
endpackage

// File: rtl/obl_ctrl.sv
module obl_ctrl
  import obl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWrite,
  output obl_strobe_t       strobes,
  output logic              lockedQ
);
  logic winHit;

  always_comb begin
    winHit       = cpuWrite && (cpuAddr[WIN_MSB:WIN_LSB] == WIN_MATCH);
    strobes.hit  = winHit;
    strobes.load = winHit && !lockedQ;
  end

  always_ff @(posedge clk) begin
    if (rst)               lockedQ <= 1'b0;
    else if (strobes.load) lockedQ <= 1'b1;
  end
endmodule

// File: rtl/obl_datapath.sv
module obl_datapath
  import obl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  obl_strobe_t       strobes,
  input  logic [DATA_W-1:0] cpuData,
  input  logic              innerProgA17,
  input  logic              innerCharA17,
  input  logic [LOW_W-1:0]  innerProgLow,
  input  logic [LOW_W-1:0]  innerCharLow,
  output logic [DATA_W-1:0] cfgQ,
  output logic [ROM_W-1:0]  progRomAddr,
  output logic [ROM_W-1:0]  charRomAddr
);
  logic [BANK_W-1:0] progBank;
  logic [BANK_W-1:0] charBank;

  always_ff @(posedge clk) begin
    if (rst)               cfgQ <= '0;
    else if (strobes.load) cfgQ <= cpuData;
  end

  always_comb begin
    progBank[2] = cfgQ[B_SHARED];
    progBank[1] = cfgQ[B_PROG_SEL];
    progBank[0] = cfgQ[B_PROG_MODE] ? cfgQ[B_PROG_HALF] : innerProgA17;
    charBank[2] = cfgQ[B_CHAR_UPPER];
    charBank[1] = cfgQ[B_SHARED];
    charBank[0] = cfgQ[B_CHAR_MODE] ? cfgQ[B_CHAR_HALF] : innerCharA17;
    progRomAddr = {progBank, innerProgLow};
    charRomAddr = {charBank, innerCharLow};
  end
endmodule

// File: rtl/outer_bank_latch.sv
module outer_bank_latch
  import obl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuData,
  input  logic              cpuWrite,
  input  logic              innerProgA17,
  input  logic              innerCharA17,
  input  logic [LOW_W-1:0]  innerProgLow,
  input  logic [LOW_W-1:0]  innerCharLow,
  output logic [ROM_W-1:0]  progRomAddr,
  output logic [ROM_W-1:0]  charRomAddr
);
  obl_strobe_t       strobes;
  logic              lockedQ;
  logic [DATA_W-1:0] cfgQ;

  obl_ctrl ctrl_i (
    .clk(clk), .rst(rst), .cpuAddr(cpuAddr), .cpuWrite(cpuWrite),
    .strobes(strobes), .lockedQ(lockedQ)
  );

  obl_datapath dp_i (
    .clk(clk), .rst(rst), .strobes(strobes), .cpuData(cpuData),
    .innerProgA17(innerProgA17), .innerCharA17(innerCharA17),
    .innerProgLow(innerProgLow), .innerCharLow(innerCharLow),
    .cfgQ(cfgQ), .progRomAddr(progRomAddr), .charRomAddr(charRomAddr)
  );
endmodule

// File: rtl/obl_chk.sv
module obl_chk
  import obl_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic [DATA_W-1:0] cpuData,
  input logic              cpuWrite,
  input logic              innerProgA17,
  input logic              innerCharA17,
  input logic [LOW_W-1:0]  innerProgLow,
  input logic [LOW_W-1:0]  innerCharLow,
  input logic [ROM_W-1:0]  progRomAddr,
  input logic [ROM_W-1:0]  charRomAddr,
  input logic [DATA_W-1:0] cfgQ,
  input logic              lockedQ
);
  logic busHit;
  assign busHit = cpuWrite && (cpuAddr[WIN_MSB:WIN_LSB] == WIN_MATCH);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (cfgQ == '0 && !lockedQ));

  // R3
  first_load_chk: assert property (@(posedge clk) disable iff (rst)
    (busHit && !lockedQ) |=> (lockedQ && cfgQ == $past(cpuData)));

  // R4
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    lockedQ |=> (lockedQ && $stable(cfgQ)));

  // R10
  no_hit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !busHit |=> ($stable(cfgQ) && $stable(lockedQ)));

  // R6
  prog_half_chk: assert property (@(posedge clk) disable iff (rst)
    progRomAddr[LOW_W] == (cfgQ[B_PROG_MODE] ? cfgQ[B_PROG_HALF] : innerProgA17));

  // R7
  char_half_chk: assert property (@(posedge clk) disable iff (rst)
    charRomAddr[LOW_W] == (cfgQ[B_CHAR_MODE] ? cfgQ[B_CHAR_HALF] : innerCharA17));

  // R8
  shared_bit_chk: assert property (@(posedge clk) disable iff (rst)
    progRomAddr[ROM_W-1] == charRomAddr[LOW_W+1]);

  // R9
  low_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (progRomAddr[LOW_W-1:0] == innerProgLow) && (charRomAddr[LOW_W-1:0] == innerCharLow));
endmodule

bind outer_bank_latch obl_chk chk_i (
  .clk(clk), .rst(rst), .cpuAddr(cpuAddr), .cpuData(cpuData), .cpuWrite(cpuWrite),
  .innerProgA17(innerProgA17), .innerCharA17(innerCharA17),
  .innerProgLow(innerProgLow), .innerCharLow(innerCharLow),
  .progRomAddr(progRomAddr), .charRomAddr(charRomAddr),
  .cfgQ(cfgQ), .lockedQ(lockedQ)
);

// File: tb/outer_bank_latch_tb_top.sv
`timescale 1ns/1ps
module outer_bank_latch_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuData = '0;
  logic        cpuWrite = 1'b0;
  logic        innerProgA17 = 1'b0;
  logic        innerCharA17 = 1'b0;
  logic [16:0] innerProgLow = '0;
  logic [16:0] innerCharLow = '0;
  logic [19:0] progRomAddr;
  logic [19:0] charRomAddr;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  outer_bank_latch dut_i (.*);

  function automatic logic [2:0] expProg(logic [7:0] b, logic a17);
    return (b & 8'h06) | ((b[3] ? b[0] : a17) ? 3'd1 : 3'd0);
  endfunction

  function automatic logic [2:0] expChar(logic [7:0] b, logic a17);
    return 3'(b[5] * 4 + b[2] * 2) | ((b[6] ? b[4] : a17) ? 3'd1 : 3'd0);
  endfunction

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic doWrite(logic [15:0] a, logic [7:0] d, logic we);
    @(negedge clk); cpuAddr = a; cpuData = d; cpuWrite = we;
    @(negedge clk); cpuWrite = 1'b0;
  endtask

  // checks outputs for byte b under all inner A17 combinations
  task automatic checkByte(logic [7:0] b, string req);
    for (int k = 0; k < 4; k++) begin
      innerProgA17 = k[0];
      innerCharA17 = k[1];
      innerProgLow = 17'((k * 12345 + b * 7) & 17'h1FFFF);
      innerCharLow = 17'((k * 54321 + b * 3) & 17'h1FFFF);
      #1;
      checks++;
      if (progRomAddr !== {expProg(b, k[0]), innerProgLow}) begin
        errors++;
        $display("FAIL %s prog byte=%02h got %05h exp %05h", req, b, progRomAddr,
                 {expProg(b, k[0]), innerProgLow});
      end
      checks++;
      if (charRomAddr !== {expChar(b, k[1]), innerCharLow}) begin
        errors++;
        $display("FAIL %s char byte=%02h got %05h exp %05h", req, b, charRomAddr,
                 {expChar(b, k[1]), innerCharLow});
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired got running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset value
    checkByte(8'h00, "R1");
    // R10 writes outside the window or without the strobe
    doWrite(16'h8000, 8'h7F, 1'b1); checkByte(8'h00, "R10");
    doWrite(16'h5FFF, 8'h7F, 1'b1); checkByte(8'h00, "R10");
    doWrite(16'h6800, 8'h7F, 1'b0); checkByte(8'h00, "R10");
    // R2 R3 first write at odd in-window address is taken
    doWrite(16'h7FFF, 8'h5A, 1'b1); checkByte(8'h5A, "R3");
    // R4 later writes ignored
    doWrite(16'h6800, 8'h7F, 1'b1); checkByte(8'h5A, "R4");
    doWrite(16'h6000, 8'h00, 1'b1); checkByte(8'h5A, "R4");
    // R4 re-arm after reset
    doReset(); checkByte(8'h00, "R1");
    doWrite(16'h6800, 8'h2D, 1'b1); checkByte(8'h2D, "R4");
    // R5 R6 R7 R8 R9 sweep of every byte value
    for (int v = 0; v < 256; v++) begin
      doReset();
      doWrite(16'h6000 + 16'(v * 31), 8'(v), 1'b1);
      checkByte(8'(v), "R6_R7");
    end
    // R5 bit 7 has no effect: 0x80 must look like 0x00
    doReset(); doWrite(16'h6800, 8'h80, 1'b1); checkByte(8'h00, "R5");
    // R8 only the shared bit set
    doReset(); doWrite(16'h6800, 8'h04, 1'b1); checkByte(8'h04, "R8");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule